// File: doc/BRIEF.md
# FIFO with Marked Synchronous Retransmit

A single-clock synchronous FIFO (32 bits by 512 words by default) whose read side can mark the word it is presenting and later rewind to it. The marked vector can then be replayed as many times as needed. A typical use is to feed a fixed block of coefficients, again and again, to a multiply-accumulate engine that consumes them in sequence.

The read port holds its head word in an output register, first-word-fall-through style. Two control inputs drive the retransmit feature. `hold_mark` enters or leaves retransmit mode. `replay` rewinds reading to the marked word. While the block is in retransmit mode, a shadow pointer keeps the marked location. The write-side flags measure fill against this shadow pointer, so the marked data cannot be overwritten, and writes may still continue until the space in front of the mark is used up. The read-side flags always measure fill against the live head pointer. The flag offsets are captured while reset is held.

Top module: `sync_retx_fifo`

## Requirements
- R1: While `rst_n` is low, the FIFO is emptied, retransmit mode is cleared and `af_ofs`/`ae_ofs` are captured; later changes to them have no effect. After reset, `out_rdy`=0, `in_rdy`=1, `almost_full_n`=1 and `almost_empty_n`=0.
- R2: Words are read in the order they were written. On an empty FIFO, a written word appears on `rd_data` with `out_rdy`=1 after the second rising edge. An edge with `rd_en` and `out_rdy` both high consumes the head word and presents the next one.
- R3: The write-side fill is the number of words from the reference pointer to the write pointer. The reference pointer is the shadow pointer in retransmit mode and the head pointer otherwise. `in_rdy` is low exactly when this fill equals DEPTH, and a write while `in_rdy` is low is dropped.
- R4: `almost_full_n` is low exactly when the write-side fill is at least DEPTH minus the captured `af_ofs`.
- R5: `almost_empty_n` is low exactly when the number of unread words, counting the word in the output register, is at most the captured `ae_ofs`.
- R6: A rising edge with `hold_mark`=1 and `out_rdy`=1, outside retransmit mode, enters the mode. The word on `rd_data` at that edge becomes the marked word. With `out_rdy`=0 the mode is not entered.
- R7: A rising edge with `hold_mark`=0 leaves retransmit mode. At that same edge a `replay` request is ignored. From then on, `in_rdy` and `almost_full_n` are measured from the head pointer.
- R8: In retransmit mode, once at least two words have been consumed since the mark, an edge with `replay`=1 and `hold_mark`=1 puts the marked word on `rd_data` with `out_rdy`=1. A `rd_en` on that edge consumes nothing. Later reads continue in order from the mark, and the replay can be repeated.
- R9: A `replay` request is ignored outside retransmit mode, and also while fewer than two words have been consumed since the mark.
- R10: In retransmit mode, reads do not free write space. Writes are accepted until exactly DEPTH words are stored from the marked word onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; offsets captured while low |
| af_ofs | input | 9 | Almost-full offset |
| ae_ofs | input | 9 | Almost-empty offset |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| in_rdy | output | 1 | High when a write will be accepted |
| almost_full_n | output | 1 | Low when write-side fill is near DEPTH |
| rd_en | input | 1 | Consume the head word |
| rd_data | output | 32 | Output register (head word) |
| out_rdy | output | 1 | High when `rd_data` holds a valid word |
| almost_empty_n | output | 1 | Low when few unread words remain |
| hold_mark | input | 1 | High to enter or stay in retransmit mode, low to leave |
| replay | input | 1 | Rewind reading to the marked word |

## Verification
A wrong head pointer appears on `rd_data` on the edge after the bad update. It shows up as a skipped or repeated word, or as a replay that lands on the wrong word. A corrupt shadow pointer or mode bit stays hidden until the write side fills. It then shows as `in_rdy` falling after too few or too many writes past the mark, or as `in_rdy` failing to recover on the edge that leaves the mode. For that reason the bench fills the FIFO completely while a mark is held, and counts the writes it accepts.

// File: rtl/sync_retx_fifo.sv
module sync_retx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  parameter int OW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] af_ofs,
  input  logic [OW-1:0] ae_ofs,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic          in_rdy,
  output logic          almost_full_n,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          out_rdy,
  output logic          almost_empty_n,
  input  logic          hold_mark,
  input  logic          replay
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, hp, sp, nhp;
  logic [OW-1:0] af_q, ae_q;
  logic [W-1:0]  dq;
  logic [1:0]    rcnt;
  logic          mode, ov;

  wire [PW-1:0] ref_p  = mode ? sp : hp;
  wire [PW-1:0] used_w = wp - ref_p;
  wire [PW-1:0] used_r = wp - hp;

  assign in_rdy         = used_w != FULL;
  assign almost_full_n  = used_w < (FULL - PW'(af_q));
  assign almost_empty_n = used_r > PW'(ae_q);
  assign out_rdy        = ov;
  assign rd_data        = dq;

  wire wr_ok = wr_en & in_rdy;
  wire take  = rd_en & ov;
  wire enter = !mode & hold_mark & ov;
  wire leave = mode & !hold_mark;
  wire rpl   = mode & hold_mark & replay & rcnt[1];

  assign nhp = rpl ? sp : hp + PW'(take);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      hp   <= '0;
      sp   <= '0;
      ov   <= 1'b0;
      dq   <= '0;
      mode <= 1'b0;
      rcnt <= '0;
      af_q <= af_ofs;
      ae_q <= ae_ofs;
    end else begin
      wp <= wp + PW'(wr_ok);
      hp <= nhp;
      ov <= wp != nhp;
      dq <= mem[nhp[AW-1:0]];
      if (enter) begin
        mode <= 1'b1;
        sp   <= hp;
        rcnt <= {1'b0, take};
      end else if (leave) begin
        mode <= 1'b0;
      end else if (rpl) begin
        rcnt <= '0;
      end else if (mode && take && !rcnt[1]) begin
        rcnt <= rcnt + 2'd1;
      end
    end
  end

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used_w <= FULL);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rdy && wr_en) |=> $stable(wp));
  p_af_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rdy |-> !almost_full_n);
  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && hold_mark && out_rdy) |=> mode);
  p_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !hold_mark) |=> (!mode && $stable(sp)));
  p_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && hold_mark && replay && rcnt == 2'd2) |=> (hp == $past(sp) && out_rdy));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !(rd_en && out_rdy)) |=> $stable(hp));
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && hold_mark) |=> $stable(sp));
endmodule

// File: tb/sim_sync_retx_fifo.sv
module sim_sync_retx_fifo;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 512;
  localparam int AF     = 16;
  localparam int AE     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] af_ofs = 9'(AF), ae_ofs = 9'(AE);
  logic wr_en = 0, rd_en = 0, hold_mark = 0, replay = 0;
  logic [31:0] wr_data = '0;
  logic in_rdy, almost_full_n, out_rdy, almost_empty_n;
  logic [31:0] rd_data;

  always #(PERIOD/2) clk = ~clk;

  sync_retx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .in_rdy(in_rdy), .almost_full_n(almost_full_n),
    .rd_en(rd_en), .rd_data(rd_data), .out_rdy(out_rdy), .almost_empty_n(almost_empty_n),
    .hold_mark(hold_mark), .replay(replay));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int store [32768];
  int m_wp = 0, m_h = 0, m_sh = 0, m_rc = 0;
  bit m_mode = 0, m_ov = 0;

  function automatic int used_w();
    return m_wp - (m_mode ? m_sh : m_h);
  endfunction
  function automatic bit exp_in_rdy();
    return used_w() != DEPTH;
  endfunction
  function automatic bit exp_afn();
    return used_w() < DEPTH - AF;
  endfunction
  function automatic bit exp_aen();
    return (m_wp - m_h) > AE;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input int d, input bit r, input bit mi, input bit rp);
    bit inr, cons, wok, ent, lv, rpl;
    int nh;
    inr  = exp_in_rdy();
    cons = r && m_ov;
    wok  = w && inr;
    ent  = !m_mode && mi && m_ov;
    lv   = m_mode && !mi;
    rpl  = m_mode && mi && rp && m_rc >= 2;
    nh   = rpl ? m_sh : m_h + int'(cons);
    m_ov = m_wp != nh;
    if (wok) begin
      store[m_wp] = d;
      m_wp++;
    end
    if (ent) begin
      m_mode = 1; m_sh = m_h; m_rc = int'(cons);
    end else if (lv) m_mode = 0;
    else if (rpl) m_rc = 0;
    else if (m_mode && cons && m_rc < 2) m_rc++;
    m_h = nh;
  endtask

  task automatic compare();
    chk("R2 out_rdy", out_rdy, 32'(m_ov));
    if (m_ov) chk("R2/R8 rd_data", rd_data, store[m_h]);
    chk("R3 in_rdy", in_rdy, 32'(exp_in_rdy()));
    chk("R4 almost_full_n", almost_full_n, 32'(exp_afn()));
    chk("R5 almost_empty_n", almost_empty_n, 32'(exp_aen()));
  endtask

  task automatic cyc(input bit w, input int d, input bit r, input bit mi, input bit rp);
    wr_en = w; wr_data = d; rd_en = r; hold_mark = mi; replay = rp;
    @(posedge clk);
    model_step(w, d, r, mi, rp);
    #1;
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, af_k;
    bit mi_s;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    af_ofs = 9'd200;
    ae_ofs = 9'd100;
    #1;
    chk("R1 out_rdy", out_rdy, 0);
    chk("R1 in_rdy", in_rdy, 1);
    chk("R1 almost_full_n", almost_full_n, 1);
    chk("R1 almost_empty_n", almost_empty_n, 0);

    for (int i = 0; i < 10; i++) cyc(1, 100 + i, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R2 first word", rd_data, 100);
    chk("R1 offset kept (ae=4, 10 words)", almost_empty_n, 1);

    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R2 next word", rd_data, 101);
    cyc(0, 0, 0, 1, 1);
    chk("R9 early replay ignored", rd_data, 101);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 1, 1);
    chk("R8 replay to mark", rd_data, 100);
    cyc(0, 0, 0, 1, 0);
    chk("R8 read on replay edge not consumed", rd_data, 100);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 0);
    chk("R8 order after replay", rd_data, 103);
    cyc(0, 0, 0, 1, 1);
    chk("R8 repeated replay", rd_data, 100);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7 leave beats replay", rd_data, 102);
    cyc(0, 0, 0, 0, 1);
    chk("R9 replay outside mode", rd_data, 102);

    cyc(0, 0, 0, 1, 0);
    k = 0; af_k = -1;
    while (in_rdy && k < 2000) begin
      cyc(1, 1000 + k, (k % 3) == 0, 1, 0);
      k++;
      if (!almost_full_n && af_k < 0) af_k = k;
    end
    chk("R10 writes accepted past mark", k, 504);
    chk("R4 almost_full_n fall point", af_k, 488);
    cyc(1, 32'hdead, 1, 1, 0);
    chk("R10 read frees nothing in mode", in_rdy, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 reference switches on leave", in_rdy, 1);
    while (out_rdy) cyc(0, 0, 1, 0, 0);
    chk("R5 empty after drain", almost_empty_n, 0);
    chk("R2 empty after drain", out_rdy, 0);

    cyc(0, 0, 0, 1, 0);
    chk("R6 no entry while empty", in_rdy, 1);
    cyc(1, 7, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    mi_s = 0;
    for (int c = 0; c < 5000; c++) begin
      bit w, r;
      if (($urandom % 40) == 0) mi_s = !mi_s;
      if (c < 2500) begin
        w = ($urandom % 4) != 0; r = ($urandom % 4) == 0;
      end else begin
        w = ($urandom % 4) == 0; r = ($urandom % 4) != 0;
      end
      cyc(w, int'($urandom), r, mi_s, ($urandom % 8) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule